// File: doc/BRIEF.md
# UART Receive Character Buffer with Overrun Control

This block is the receive-side store of a 16550-style UART. It sits between the serial deserializer, which hands over one complete character per pulse, and the memory-mapped register file. Characters are kept either in a single holding slot, when the FIFO is off, or in a ring of `DEPTH` slots, when the FIFO is on. Software drains the buffer by strobing the receive-data read once per character. It polls the line status with single reads.

No access is ever held off. Every strobe takes effect in the cycle it is presented. When storage has no room for an arriving character, the block records an overrun instead of stalling anything. The loss policy depends on the mode. With the FIFO on, the late character is thrown away and the stored ones are kept. With the FIFO off, the late character replaces the unread one. The overrun indication stays set until the status is read. It drives an interrupt request only when the line-status interrupt enable is high.

Top module: `uart_rx_store`

## Requirements
- R1: A pulse on `rd_data_stb` while characters are held puts the oldest held character on `rd_data` after the next clock edge and removes it. Strobes on consecutive cycles return the characters in arrival order, one per strobe.
- R2: With `fifo_en` low, a character that arrives while the holding slot is occupied and not being read replaces the held character and sets `overrun`.
- R3: With `fifo_en` high, a character that arrives while `DEPTH` characters are held and none is being read is discarded, the held characters are unchanged, and `overrun` is set.
- R4: A character that arrives in the same cycle as a data read of a full buffer takes the freed place, and no overrun is flagged. This holds in both modes.
- R5: `overrun` stays high until a pulse on `rd_lsr_stb` clears it after the next edge. If an overrun occurs in the same cycle as that pulse, the flag stays high.
- R6: `irq_lsr` is high exactly when `overrun` is high and `lsr_int_en` is high.
- R7: `data_ready` is high exactly when at least one character is held.
- R8: A data read of an empty buffer leaves `rd_data` at its previous value and changes no other output.
- R9: A pulse on `fifo_clr`, or any change of `fifo_en`, empties the buffer within the same edge. A character arriving in that cycle is discarded, a data read in that cycle pops nothing, and `overrun` is unaffected.
- R10: After reset, `rd_data` is 0 and `data_ready`, `overrun` and `irq_lsr` are low.
- R11: With `fifo_en` high, up to `DEPTH` characters (16 by default) are held without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | One-cycle pulse: a complete character is present on `char_data` |
| char_data | input | DATA_W | Character from the deserializer |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding slot |
| fifo_clr | input | 1 | One-cycle pulse: empty the buffer |
| lsr_int_en | input | 1 | Line-status interrupt enable |
| rd_data_stb | input | 1 | One-cycle data-register read strobe |
| rd_lsr_stb | input | 1 | One-cycle line-status read strobe |
| rd_data | output | DATA_W | Last character read out |
| data_ready | output | 1 | At least one character is held |
| overrun | output | 1 | Sticky overrun indication |
| irq_lsr | output | 1 | Line-status interrupt request |

## Verification
Two pairs of events can land on the same edge. An arriving character can meet a data read of a full buffer, and an overrun can meet the status read that would clear the flag. The bench drives each pair on one strobe cycle in both modes. It judges the first pair by the absence of an overrun and by the order of later reads. It judges the second by the flag still being high on the following cycle. A reference model in the bench applies the pop before the admission and the set after the clear, and a scoreboard compares every data read against it.

// File: rtl/uart_rxb_pkg.sv
`timescale 1ns/1ps
package uart_rxb_pkg;

   // Decision for one arriving character
   typedef struct packed {
      logic push;     // append at tail
      logic ovwr;     // replace head (holding-slot mode only)
      logic ovr_evt;  // character found no room
   } rxb_admit_t;

   function automatic int unsigned cnt_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/uart_rxb_store.sv
`timescale 1ns/1ps
module uart_rxb_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = uart_rxb_pkg::cnt_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic              ovwr,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_rxb_store: DEPTH must be a power of two and at least 2");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_rxb_store: DATA_W must lie between 5 and 9");
      end
   endgenerate

   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [DATA_W-1:0] slots [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      logic              wr_here;
      assign wr_here = (push && wr_ptr == PTR_W'(i)) || (ovwr && rd_ptr == PTR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       slot_q <= '0;
         else if (wr_here) slot_q <= wdata;
      end
      assign slots[i] = slot_q;
   end

   assign head = slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R11
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (count != CNT_W'(DEPTH)));

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

   // R2
   ovwr_only_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovwr |-> (count == CNT_W'(1)) && !push && !pop);

endmodule

// File: rtl/uart_rxb_admit.sv
`timescale 1ns/1ps
module uart_rxb_admit #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = uart_rxb_pkg::cnt_bits(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     char_valid,
   input  logic                     fifo_mode,
   input  logic                     flush,
   input  logic                     rd_req,
   input  logic [CNT_W-1:0]         count,
   output logic                     pop,
   output uart_rxb_pkg::rxb_admit_t adm
);

   logic full_eff;
   logic room;
   logic arrive;

   // Capacity follows the mode: the whole ring, or a single slot
   assign full_eff = fifo_mode ? (count == CNT_W'(DEPTH)) : (count != '0);
   assign pop      = rd_req && !flush && (count != '0);
   assign room     = !full_eff || pop;
   assign arrive   = char_valid && !flush;

   always_comb begin
      adm.push    = arrive && room;
      adm.ovr_evt = arrive && !room;
      adm.ovwr    = arrive && !room && !fifo_mode;
   end

   // R3
   fifo_keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adm.ovr_evt && fifo_mode) |=> (count == CNT_W'(DEPTH)));

   // R2
   hold_stays_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adm.ovr_evt && !fifo_mode) |=> (count == CNT_W'(1)));

   // R4
   pop_frees_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && pop) |-> !adm.ovr_evt);

endmodule

// File: rtl/uart_rxb_status.sv
`timescale 1ns/1ps
module uart_rxb_status (
   input  logic clk,
   input  logic rst_n,
   input  logic ovr_evt,
   input  logic lsr_rd,
   input  logic int_en,
   output logic ovr_flag,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_flag <= 1'b0;
      else if (ovr_evt) ovr_flag <= 1'b1;
      else if (lsr_rd)  ovr_flag <= 1'b0;
   end

   assign irq = ovr_flag && int_en;

   // R5
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ovr_flag);

   // R5
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !lsr_rd) |=> ovr_flag);

   // R5
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ovr_evt) |=> !ovr_flag);

endmodule

// File: rtl/uart_rx_store.sv
`timescale 1ns/1ps
module uart_rx_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_valid,
   input  logic [DATA_W-1:0] char_data,
   input  logic              fifo_en,
   input  logic              fifo_clr,
   input  logic              lsr_int_en,
   input  logic              rd_data_stb,
   input  logic              rd_lsr_stb,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_ready,
   output logic              overrun,
   output logic              irq_lsr
);

   localparam int unsigned CNT_W = uart_rxb_pkg::cnt_bits(DEPTH);

   uart_rxb_pkg::rxb_admit_t adm;
   logic              fifo_en_q;
   logic              flush;
   logic              pop;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fifo_en_q <= 1'b0;
      else        fifo_en_q <= fifo_en;
   end

   assign flush = fifo_clr || (fifo_en != fifo_en_q);

   uart_rxb_admit #(.DEPTH(DEPTH)) u_admit (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_valid (char_valid),
      .fifo_mode  (fifo_en),
      .flush      (flush),
      .rd_req     (rd_data_stb),
      .count      (count),
      .pop        (pop),
      .adm        (adm)
   );

   uart_rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (adm.push),
      .ovwr  (adm.ovwr),
      .pop   (pop),
      .wdata (char_data),
      .head  (head),
      .count (count)
   );

   uart_rxb_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovr_evt  (adm.ovr_evt),
      .lsr_rd   (rd_lsr_stb),
      .int_en   (lsr_int_en),
      .ovr_flag (overrun),
      .irq      (irq_lsr)
   );

   // Read register: loads only on a real pop, holds otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_data <= '0;
      else if (pop) rd_data <= head;
   end

   assign data_ready = (count != '0);

   // R8
   empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_stb && !data_ready) |=> $stable(rd_data));

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !data_ready);

   // R2
   hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !fifo_en_q) |-> (count <= CNT_W'(1)));

   // R6
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adm.ovr_evt && lsr_int_en) |=> (irq_lsr || !lsr_int_en));

endmodule

// File: tb/uart_rx_store_tb.sv
`timescale 1ns/1ps
module uart_rx_store_tb;

   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              char_valid = 1'b0;
   logic [DATA_W-1:0] char_data = '0;
   logic              fifo_en = 1'b0;
   logic              fifo_clr = 1'b0;
   logic              lsr_int_en = 1'b0;
   logic              rd_data_stb = 1'b0;
   logic              rd_lsr_stb = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              data_ready, overrun, irq_lsr;

   always #2.5 clk = ~clk;

   uart_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
      .fifo_en(fifo_en), .fifo_clr(fifo_clr), .lsr_int_en(lsr_int_en),
      .rd_data_stb(rd_data_stb), .rd_lsr_stb(rd_lsr_stb), .rd_data(rd_data),
      .data_ready(data_ready), .overrun(overrun), .irq_lsr(irq_lsr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [DATA_W-1:0] mq[$];
   logic [DATA_W-1:0] exp_q[$];
   logic [DATA_W-1:0] m_last = '0;
   bit m_ovr = 0;
   bit m_mode = 0;
   bit rd_pend = 0;
   bit done = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Driver: one cycle of stimulus, reference model updated in step
   task automatic step(input bit cv, input logic [DATA_W-1:0] cd, input bit rd,
                       input bit lsr, input bit clr, input bit mode);
      bit flush, pop, evt;
      int cap;
      flush = clr || (mode != m_mode);
      pop   = rd && !flush && (mq.size() > 0);
      if (rd) exp_q.push_back(pop ? mq[0] : m_last);
      if (pop) m_last = mq.pop_front();
      if (flush) mq.delete();
      m_mode = mode;
      cap = m_mode ? DEPTH : 1;
      evt = 0;
      if (cv && !flush) begin
         if (mq.size() < cap) mq.push_back(cd);
         else begin
            evt = 1;
            if (!m_mode) mq[0] = cd;
         end
      end
      if (lsr && !evt) m_ovr = 0;
      if (evt) m_ovr = 1;
      char_valid = cv; char_data = cd; rd_data_stb = rd;
      rd_lsr_stb = lsr; fifo_clr = clr; fifo_en = mode;
      @(negedge clk);
      char_valid = 0; rd_data_stb = 0; rd_lsr_stb = 0; fifo_clr = 0;
      check("R7", data_ready, mq.size() != 0);
      check("R5", overrun, m_ovr);
      check("R6", irq_lsr, m_ovr && lsr_int_en);
   endtask

   task automatic send(input logic [DATA_W-1:0] d); step(1, d, 0, 0, 0, m_mode); endtask
   task automatic rd();                              step(0, 0, 1, 0, 0, m_mode); endtask
   task automatic lsr();                             step(0, 0, 0, 1, 0, m_mode); endtask

   // Monitor: compare each data read against the scoreboard
   always @(posedge clk) rd_pend <= rd_data_stb && rst_n;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) check("R1", rd_data, 32'hDEAD);
         else check("R1", rd_data, exp_q.pop_front());
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10", rd_data, 0);
      check("R10", {data_ready, overrun, irq_lsr}, 0);
      lsr_int_en = 1'b1;

      // Holding-slot mode: basic read, empty read
      send(8'hA5); rd();
      check("R1", rd_data, 8'hA5);
      rd();
      check("R8", rd_data, 8'hA5);
      check("R8", {data_ready, overrun}, 0);

      // R2 overwrite on overrun
      send(8'h11); send(8'h22);
      check("R2", overrun, 1);
      check("R6", irq_lsr, 1);
      rd();
      check("R2", rd_data, 8'h22);
      lsr();
      check("R5", overrun, 0);

      // R4 holding slot: arrival with a read in one cycle
      send(8'h33);
      step(1, 8'h44, 1, 0, 0, 0);
      check("R4", rd_data, 8'h33);
      check("R4", overrun, 0);
      rd();
      check("R4", rd_data, 8'h44);

      // Switch to FIFO mode, fill to depth
      step(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < DEPTH; i++) send(8'h40 + 8'(i));
      check("R11", overrun, 0);
      send(8'hEE);
      check("R3", overrun, 1);
      lsr();
      for (int i = 0; i < DEPTH; i++) rd();
      check("R3", rd_data, 8'h4F);
      check("R3", data_ready, 0);
      rd();
      check("R8", rd_data, 8'h4F);

      // R4 FIFO full: read and arrival together
      for (int i = 0; i < DEPTH; i++) send(8'h60 + 8'(i));
      step(1, 8'h77, 1, 0, 0, 1);
      check("R4", overrun, 0);
      // R5 overrun in same cycle as status read: stays set
      step(1, 8'h88, 0, 1, 0, 1);
      check("R5", overrun, 1);
      lsr();
      check("R5", overrun, 0);
      for (int i = 0; i < DEPTH; i++) rd();
      check("R4", rd_data, 8'h77);

      // R6 interrupt gating
      lsr_int_en = 1'b0;
      for (int i = 0; i < DEPTH + 1; i++) send(8'h10 + 8'(i));
      check("R6", {overrun, irq_lsr}, 2'b10);
      lsr_int_en = 1'b1;
      #1;
      check("R6", irq_lsr, 1);

      // R9 clear with arriving character: empty, flag untouched
      step(1, 8'h99, 0, 0, 1, 1);
      check("R9", data_ready, 0);
      check("R9", overrun, 1);
      lsr();
      rd();
      check("R9", rd_data, 8'h77);
      // R9 mode toggle empties
      send(8'h5A); send(8'h5B);
      step(1, 8'h5C, 1, 0, 0, 0);
      check("R9", data_ready, 0);
      check("R9", rd_data, 8'h77);
      send(8'h6D); rd();
      check("R9", rd_data, 8'h6D);

      repeat (2) @(negedge clk);
      check("R1", exp_q.size(), 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule